// File: doc/BRIEF.md
# Hierarchical Address Translation Walker

This block turns a 32-bit virtual address into a physical address. It reads translation entries from memory one level at a time, starting at a root pointer. A static mode input selects the table shape:

- **Legacy mode** uses two levels of 4-byte entries.
- **Extended mode** uses three levels of 8-byte entries and yields a 36-bit physical address.

A directory entry can end the walk early as a large-page leaf. The walker checks the write and user permissions of the leaf entry. It then marks the leaf as accessed and, for writes, as dirty, by writing the entry back. The write-back happens only when the entry changes.

A client raises a request with the address, a write flag and a user flag. It waits while `busy` is high and collects the result from a one-cycle response pulse. The response carries either a physical address or a fault. A fault reports its cause and the level at which the walk stopped. The table memory sits behind a simple port that serves one access at a time and completes each access with an acknowledge.

Top module: `xw_walker`

## Requirements
- R1: `req_ready` is high only while the walker is idle. A request is taken when `req_valid` and `req_ready` are both high at a clock edge. `busy` stays high from the next cycle until the response cycle, inclusive. `resp_valid` is a single-cycle pulse, and the walker is idle again in the cycle after it.
- R2: Legacy mode (`ext_mode`=0) reads up to two entries:
  - the directory entry at {4'b0, root[31:12], va[31:22], 2'b00};
  - the table entry at {4'b0, pde[31:12], va[21:12], 2'b00}.
  A table leaf gives the physical address {4'b0, pte[31:12], va[11:0]}. Only entry bits [31:0] are read, and `mem_wdata[31:0]` carries write-back data.
- R3: Extended mode (`ext_mode`=1) reads up to three 8-byte entries:
  - the pointer entry at {4'b0, root[31:5], va[31:30], 3'b000};
  - the directory entry at {ptr[35:12], va[29:21], 3'b000};
  - the table entry at {pde[35:12], va[20:12], 3'b000}.
  A table leaf gives {pte[35:12], va[11:0]}.
- R4: A valid directory entry with bit 7 set is a large-page leaf. In legacy mode the physical address is {4'b0, pde[31:22], va[21:0]}. In extended mode it is {pde[35:21], va[20:0]}. Bit 7 of a pointer entry is ignored.
- R5: An entry with bit 0 clear ends the walk with cause 1 (absent). The reported level is that entry's level (0 pointer, 1 directory, 2 table). No write-back follows.
- R6: A user request (`req_user`=1) whose leaf has bit 2 clear faults with cause 3. This check takes priority over the write check.
- R7: A write request whose leaf has bit 1 clear faults with cause 2. The reported level is the leaf's level.
- R8: On success, the leaf entry is written back at its own address. The written value has bit 5 set, and bit 6 also set for a write. Every other bit keeps its fetched value, and no bit is ever cleared.
- R9: No write-back is issued when bit 5 (and bit 6 for a write) of the leaf are already set.
- R10: `mem_req` and its address, write flag and data stay stable until the cycle in which `mem_ack` is high.
- R11: A successful response reports cause 0. On any fault, `resp_pa` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_mode | input | 1 | 0 legacy, 1 extended; changed only in reset |
| root_ptr | input | 32 | Root table pointer |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| busy | output | 1 | Walk in progress |
| resp_valid | output | 1 | Result pulse |
| resp_pa | output | 36 | Physical address |
| resp_cause | output | 2 | 0 none, 1 absent, 2 write protect, 3 user |
| resp_level | output | 2 | Level where the walk ended |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 36 | Byte address of entry |
| mem_wdata | output | 64 | Entry write data |
| mem_rdata | input | 64 | Entry read data, valid with ack |
| mem_ack | input | 1 | Access complete |

## Verification
Some internal faults would show up on the memory port first:
- A wrong level counter or a stale base frame shows as a wrong `mem_addr` on the very next fetch.
- A corrupted write-back value shows in the leaf entry as soon as the acknowledge for that write arrives.

Other faults show up in the response:
- A wrong leaf or permission decision shows in `resp_pa`, `resp_cause` or `resp_level` in the response cycle.
- A skipped or extra write-back changes how many write cycles occur before that pulse.

The bench walks tables filled at random in both modes and compares every response, every write-back count and every updated entry against its own walk.

// File: rtl/xw_pkg.sv
package xw_pkg;
    localparam int VA_W   = 32;
    localparam int PA_W   = 36;
    localparam int ENT_W  = 64;
    localparam int PFN_W  = 24;
    localparam int OFS_W  = 12;
    localparam int LVL_W  = 2;

    // entry flag bit positions
    localparam int B_VALID = 0;
    localparam int B_WRITE = 1;
    localparam int B_USER  = 2;
    localparam int B_ACC   = 5;
    localparam int B_DIRTY = 6;
    localparam int B_LARGE = 7;

    localparam logic [1:0] FC_NONE   = 2'd0;
    localparam logic [1:0] FC_ABSENT = 2'd1;
    localparam logic [1:0] FC_WPROT  = 2'd2;
    localparam logic [1:0] FC_USER   = 2'd3;

    typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_WRITE, ST_RESP} st_e;
    typedef enum logic [1:0] {EV_NEXT, EV_LEAF, EV_FAULT} ev_e;

    typedef struct packed {
        st_e               st;
        logic [LVL_W-1:0]  lvl;
        logic [VA_W-1:0]   va;
        logic              wr;
        logic              usr;
        logic [PFN_W-1:0]  base;
        logic [PA_W-1:0]   eaddr;
        logic [ENT_W-1:0]  wdata;
        logic [PA_W-1:0]   pa;
        logic [1:0]        cause;
    } walk_t;
endpackage

// File: rtl/xw_index.sv
module xw_index
    import xw_pkg::*;
(
    input  logic              ext,
    input  logic [LVL_W-1:0]  lvl,
    input  logic [VA_W-1:0]   va,
    input  logic [31:0]       root,
    input  logic [PFN_W-1:0]  base,
    output logic [PA_W-1:0]   addr
);
    always_comb begin
        if (lvl == 2'd0) begin
            addr = {4'b0, root[31:5], va[31:30], 3'b000};
        end else if (lvl == 2'd1) begin
            addr = ext ? {base, va[29:21], 3'b000}
                       : {4'b0, root[31:12], va[31:22], 2'b00};
        end else begin
            addr = ext ? {base, va[20:12], 3'b000}
                       : {base, va[21:12], 2'b00};
        end
    end
endmodule

// File: rtl/xw_eval.sv
module xw_eval
    import xw_pkg::*;
(
    input  logic              ext,
    input  logic [LVL_W-1:0]  lvl,
    input  logic [VA_W-1:0]   va,
    input  logic [ENT_W-1:0]  e_raw,
    input  logic              wr,
    input  logic              usr,
    output ev_e               ev,
    output logic [1:0]        cause,
    output logic [PFN_W-1:0]  next_base,
    output logic [PA_W-1:0]   pa,
    output logic [ENT_W-1:0]  wb_data,
    output logic              wb_need
);
    logic [ENT_W-1:0] e;
    logic             leaf;

    always_comb begin
        e         = ext ? e_raw : {32'b0, e_raw[31:0]};
        next_base = ext ? e[35:12] : {4'b0, e[31:12]};
        leaf      = (lvl == 2'd2) || ((lvl == 2'd1) && e[B_LARGE]);
        ev        = EV_NEXT;
        cause     = FC_NONE;
        pa        = '0;
        if (!e[B_VALID]) begin
            ev    = EV_FAULT;
            cause = FC_ABSENT;
        end else if (!leaf) begin
            ev    = EV_NEXT;
        end else if (usr && !e[B_USER]) begin
            ev    = EV_FAULT;
            cause = FC_USER;
        end else if (wr && !e[B_WRITE]) begin
            ev    = EV_FAULT;
            cause = FC_WPROT;
        end else begin
            ev = EV_LEAF;
            if (lvl == 2'd2)
                pa = {next_base, va[OFS_W-1:0]};
            else if (ext)
                pa = {e[35:21], va[20:0]};
            else
                pa = {4'b0, e[31:22], va[21:0]};
        end
        wb_data = e;
        wb_data[B_ACC] = 1'b1;
        if (wr) wb_data[B_DIRTY] = 1'b1;
        wb_need = (wb_data != e);
    end
endmodule

// File: rtl/xw_walker.sv
module xw_walker
    import xw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_mode,
    input  logic [31:0]       root_ptr,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_va,
    input  logic              req_write,
    input  logic              req_user,
    output logic              busy,
    output logic              resp_valid,
    output logic [PA_W-1:0]   resp_pa,
    output logic [1:0]        resp_cause,
    output logic [LVL_W-1:0]  resp_level,
    output logic              mem_req,
    output logic              mem_we,
    output logic [PA_W-1:0]   mem_addr,
    output logic [ENT_W-1:0]  mem_wdata,
    input  logic [ENT_W-1:0]  mem_rdata,
    input  logic              mem_ack
);
    walk_t q, d;

    logic [PA_W-1:0]  fetch_addr;
    ev_e              ev;
    logic [1:0]       ev_cause;
    logic [PFN_W-1:0] ev_base;
    logic [PA_W-1:0]  ev_pa;
    logic [ENT_W-1:0] ev_wb;
    logic             ev_wb_need;

    xw_index u_index (
        .ext  (ext_mode),
        .lvl  (q.lvl),
        .va   (q.va),
        .root (root_ptr),
        .base (q.base),
        .addr (fetch_addr)
    );

    xw_eval u_eval (
        .ext       (ext_mode),
        .lvl       (q.lvl),
        .va        (q.va),
        .e_raw     (mem_rdata),
        .wr        (q.wr),
        .usr       (q.usr),
        .ev        (ev),
        .cause     (ev_cause),
        .next_base (ev_base),
        .pa        (ev_pa),
        .wb_data   (ev_wb),
        .wb_need   (ev_wb_need)
    );

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st    = ST_FETCH;
                    d.lvl   = ext_mode ? 2'd0 : 2'd1;
                    d.va    = req_va;
                    d.wr    = req_write;
                    d.usr   = req_user;
                    d.base  = '0;
                    d.pa    = '0;
                    d.cause = FC_NONE;
                end
            end
            ST_FETCH: begin
                if (mem_ack) begin
                    d.eaddr = fetch_addr;
                    case (ev)
                        EV_NEXT: begin
                            d.base = ev_base;
                            d.lvl  = q.lvl + 2'd1;
                        end
                        EV_FAULT: begin
                            d.cause = ev_cause;
                            d.pa    = '0;
                            d.st    = ST_RESP;
                        end
                        default: begin
                            d.pa    = ev_pa;
                            d.wdata = ev_wb;
                            d.st    = ev_wb_need ? ST_WRITE : ST_RESP;
                        end
                    endcase
                end
            end
            ST_WRITE: begin
                if (mem_ack) d.st = ST_RESP;
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign req_ready  = (q.st == ST_IDLE);
    assign busy       = (q.st != ST_IDLE);
    assign resp_valid = (q.st == ST_RESP);
    assign resp_pa    = q.pa;
    assign resp_cause = q.cause;
    assign resp_level = q.lvl;
    assign mem_req    = (q.st == ST_FETCH) || (q.st == ST_WRITE);
    assign mem_we     = (q.st == ST_WRITE);
    assign mem_addr   = (q.st == ST_WRITE) ? q.eaddr : fetch_addr;
    assign mem_wdata  = (q.st == ST_WRITE) ? q.wdata : '0;
endmodule

// File: rtl/xw_walker_chk.sv
module xw_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ext_mode,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_va,
    input logic        req_write,
    input logic        req_user,
    input logic        busy,
    input logic        resp_valid,
    input logic [35:0] resp_pa,
    input logic [1:0]  resp_cause,
    input logic        mem_req,
    input logic        mem_we,
    input logic [35:0] mem_addr,
    input logic [63:0] mem_wdata,
    input logic        mem_ack
);
    logic [31:0] cap_va;
    logic        cap_wr;
    logic        cap_usr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_va  <= '0;
            cap_wr  <= 1'b0;
            cap_usr <= 1'b0;
        end else if (req_valid && req_ready) begin
            cap_va  <= req_va;
            cap_wr  <= req_write;
            cap_usr <= req_user;
        end
    end

    assert_resp_in_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> busy);
    assert_busy_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));
    assert_resp_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> (!resp_valid && !busy));
    assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
    assert_wb_accessed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_wdata[5]);
    assert_wb_dirty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && cap_wr) |-> mem_wdata[6]);
    assert_offset_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_cause == 2'd0) |-> (resp_pa[11:0] == cap_va[11:0]));
    assert_legacy_narrow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_cause == 2'd0 && !ext_mode) |-> (resp_pa[35:32] == 4'h0));
    assert_wprot_needs_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_cause == 2'd2) |-> cap_wr);
    assert_user_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_cause == 2'd3) |-> cap_usr);
    assert_fault_pa_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_cause != 2'd0) |-> (resp_pa == 36'd0));
endmodule

bind xw_walker xw_walker_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_mode   (ext_mode),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_va     (req_va),
    .req_write  (req_write),
    .req_user   (req_user),
    .busy       (busy),
    .resp_valid (resp_valid),
    .resp_pa    (resp_pa),
    .resp_cause (resp_cause),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack)
);

// File: tb/xw_walker_test.sv
`timescale 1ns/1ps
module xw_walker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_mode = 1'b0;
    logic [31:0] root_ptr = 32'h0000_3000;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        busy;
    logic        resp_valid;
    logic [35:0] resp_pa;
    logic [1:0]  resp_cause;
    logic [1:0]  resp_level;
    logic        mem_req;
    logic        mem_we;
    logic [35:0] mem_addr;
    logic [63:0] mem_wdata;
    logic [63:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    int wr_count = 0;
    logic [31:0] wmem [0:2047];

    always #5 clk = ~clk;

    xw_walker uut (
        .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .root_ptr(root_ptr),
        .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
        .req_write(req_write), .req_user(req_user), .busy(busy),
        .resp_valid(resp_valid), .resp_pa(resp_pa), .resp_cause(resp_cause),
        .resp_level(resp_level), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack)
    );

    function automatic logic [63:0] rd64(input logic [35:0] a, input logic x);
        logic [10:0] i;
        i = a[12:2];
        if (x) return {wmem[{i[10:1], 1'b1}], wmem[{i[10:1], 1'b0}]};
        return {32'b0, wmem[i]};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            mem_ack   <= 1'b1;
            mem_rdata <= rd64(mem_addr, ext_mode);
            if (mem_we) begin
                wr_count <= wr_count + 1;
                if (ext_mode) begin
                    wmem[{mem_addr[12:3], 1'b0}] <= mem_wdata[31:0];
                    wmem[{mem_addr[12:3], 1'b1}] <= mem_wdata[63:32];
                end else begin
                    wmem[mem_addr[12:2]] <= mem_wdata[31:0];
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_ent(input logic [35:0] a, input logic [63:0] v);
        if (ext_mode) begin
            wmem[{a[12:3], 1'b0}] = v[31:0];
            wmem[{a[12:3], 1'b1}] = v[63:32];
        end else begin
            wmem[a[12:2]] = v[31:0];
        end
    endtask

    task automatic ref_walk(input logic [31:0] va, input logic wr, input logic usr,
                            output logic [35:0] pa, output logic [1:0] cause, output logic [1:0] lvl,
                            output bit wb, output logic [35:0] wba, output logic [63:0] wbv);
        logic [35:0] a;
        logic [63:0] e;
        pa = '0; cause = 2'd0; lvl = 2'd1; wb = 0; wba = '0; wbv = '0;
        if (ext_mode) begin
            a = {4'h0, root_ptr[31:5], va[31:30], 3'b000};
            e = rd64(a, 1'b1);
            lvl = 2'd0;
            if (!e[0]) begin cause = 2'd1; return; end
            a = {e[35:12], va[29:21], 3'b000};
        end else begin
            a = {4'h0, root_ptr[31:12], va[31:22], 2'b00};
        end
        e = rd64(a, ext_mode);
        lvl = 2'd1;
        if (!e[0]) begin cause = 2'd1; return; end
        if (!e[7]) begin
            a = ext_mode ? {e[35:12], va[20:12], 3'b000} : {4'h0, e[31:12], va[21:12], 2'b00};
            e = rd64(a, ext_mode);
            lvl = 2'd2;
            if (!e[0]) begin cause = 2'd1; return; end
        end
        if (usr && !e[2]) begin cause = 2'd3; return; end
        if (wr && !e[1]) begin cause = 2'd2; return; end
        if (lvl == 2'd2) pa = ext_mode ? {e[35:12], va[11:0]} : {4'h0, e[31:12], va[11:0]};
        else             pa = ext_mode ? {e[35:21], va[20:0]} : {4'h0, e[31:22], va[21:0]};
        wbv = e | 64'h20 | (wr ? 64'h40 : 64'h0);
        wb  = (wbv != e);
        wba = a;
    endtask

    // one translation; returns the design's physical address
    task automatic run_req(input logic [31:0] va, input logic wr, input logic usr, input string tag,
                           output logic [35:0] got_pa);
        logic [35:0] e_pa, e_wba;
        logic [1:0]  e_cause, e_lvl;
        logic [63:0] e_wbv;
        bit          e_wb;
        int          w0, t;
        ref_walk(va, wr, usr, e_pa, e_cause, e_lvl, e_wb, e_wba, e_wbv);
        w0 = wr_count;
        @(negedge clk);
        check(req_ready == 1'b1, {"R1 ready idle ", tag}, 64'(req_ready), 64'd1);
        req_va = va; req_write = wr; req_user = usr; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        t = 0;
        while (!resp_valid && t < 200) begin
            if (!busy) check(1'b0, {"R1 busy ", tag}, 64'(busy), 64'd1);
            @(negedge clk);
            t++;
        end
        got_pa = resp_pa;
        check(resp_valid == 1'b1, {"R1 response ", tag}, 64'(resp_valid), 64'd1);
        check(resp_pa == e_pa, {"R2 R3 R4 pa ", tag}, 64'(resp_pa), 64'(e_pa));
        check(resp_cause == e_cause, {"R5 R6 R7 R11 cause ", tag}, 64'(resp_cause), 64'(e_cause));
        if (e_cause != 2'd0)
            check(resp_level == e_lvl, {"R5 level ", tag}, 64'(resp_level), 64'(e_lvl));
        check((wr_count - w0) == (e_wb ? 1 : 0), {"R8 R9 writeback count ", tag},
              64'(wr_count - w0), 64'(e_wb ? 1 : 0));
        if (e_wb)
            check(rd64(e_wba, ext_mode) == e_wbv, {"R8 entry value ", tag},
                  rd64(e_wba, ext_mode), e_wbv);
        @(negedge clk);
        check(!resp_valid && req_ready, {"R1 single pulse ", tag}, 64'(resp_valid), 64'd0);
    endtask

    task automatic do_reset(input logic mode, input logic [31:0] root);
        rst_n = 1'b0; ext_mode = mode; root_ptr = root;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && req_ready && !resp_valid && !mem_req, "R1 reset state",
              {60'b0, busy, req_ready, resp_valid, mem_req}, 64'h4);
    endtask

    task automatic fill_random();
        for (int i = 0; i < 2048; i++) begin
            logic [31:0] w;
            w = $urandom;
            w[0] = ($urandom % 8) != 0;
            wmem[i] = w;
        end
    endtask

    task automatic random_run(input int n, input string tag);
        logic [35:0] p;
        for (int k = 0; k < n; k++) begin
            if (k % 40 == 0) fill_random();
            run_req($urandom, 1'($urandom), 1'($urandom), tag, p);
        end
    endtask

    initial begin : watchdog
        #(1_500_000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [35:0] p;
        void'($urandom(32'd1234));
        for (int i = 0; i < 2048; i++) wmem[i] = '0;

        // ---------------- legacy mode ----------------
        do_reset(1'b0, 32'h0000_3000);
        set_ent(36'h3004, 64'h0000_5007);
        set_ent(36'h500C, 64'hABC0_0003);
        run_req(32'h0040_3ABC, 1'b0, 1'b1, "R6 user on supervisor leaf", p);
        run_req(32'h0040_3ABC, 1'b1, 1'b0, "R2 legacy write", p);
        check(p == 36'h0_ABC0_0ABC, "R2 legacy pa literal", 64'(p), 64'h0_ABC0_0ABC);
        check(rd64(36'h500C, 1'b0) == 64'hABC0_0063, "R8 accessed+dirty", rd64(36'h500C, 1'b0), 64'hABC0_0063);
        run_req(32'h0040_3ABC, 1'b1, 1'b0, "R9 no rewrite", p);
        set_ent(36'h500C, 64'hABC0_0001);
        run_req(32'h0040_3ABC, 1'b1, 1'b0, "R7 write protect", p);
        run_req(32'h0040_3ABC, 1'b0, 1'b0, "R8 read sets accessed only", p);
        check(rd64(36'h500C, 1'b0) == 64'hABC0_0021, "R8 read writeback", rd64(36'h500C, 1'b0), 64'hABC0_0021);
        set_ent(36'h3004, 64'h1240_0083);
        run_req(32'h0040_3ABC, 1'b0, 1'b0, "R4 legacy large", p);
        check(p == 36'h0_1240_3ABC, "R4 legacy large literal", 64'(p), 64'h0_1240_3ABC);
        set_ent(36'h3004, 64'h0);
        run_req(32'h0040_3ABC, 1'b0, 1'b0, "R5 absent directory", p);
        random_run(150, "R2 random legacy");

        // ---------------- extended mode ----------------
        for (int i = 0; i < 2048; i++) wmem[i] = '0;
        do_reset(1'b1, 32'h0000_0160);
        set_ent(36'h178, 64'h0000_0000_0000_6081);
        set_ent(36'h6018, 64'h0000_0000_0000_7007);
        set_ent(36'h7028, 64'hFFF0_0009_8765_4007);
        run_req(32'hC060_5123, 1'b1, 1'b1, "R3 extended walk", p);
        check(p == 36'h9_8765_4123, "R3 extended pa literal", 64'(p), 64'h9_8765_4123);
        check(rd64(36'h7028, 1'b1) == 64'hFFF0_0009_8765_4067, "R8 upper bits kept",
              rd64(36'h7028, 1'b1), 64'hFFF0_0009_8765_4067);
        set_ent(36'h6018, 64'h0000_0003_4560_00A7);
        run_req(32'hC060_5123, 1'b0, 1'b0, "R4 extended large", p);
        check(p == 36'h3_4560_5123, "R4 extended large literal", 64'(p), 64'h3_4560_5123);
        set_ent(36'h178, 64'h0);
        run_req(32'hC060_5123, 1'b0, 1'b0, "R5 absent pointer", p);
        random_run(150, "R3 random extended");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule